// File: doc/BRIEF.md
# Raster timing generator for RAM-less TFT panels

This block drives the timing side of a parallel RGB panel that has no memory of its own. From one pixel clock it makes the line sync, frame sync, a pixel-shift enable and a data-valid strobe. It also gives the column and line index of the pixel a frame-buffer reader must fetch next. Once reset is released it scans frames without stopping. No host action is needed for the panel to keep refreshing.

Each line is laid out as sync, back porch, active pixels and front porch. Each frame has the same four parts, counted in whole lines. All eight lengths are 12-bit inputs. The block copies them only at the start of a frame, so a host may rewrite them at any time without breaking the frame on screen. A tearing flag goes back to the host and marks the non-display period. The host can choose whether the flag shows only the vertical blanking or also the horizontal blanking inside active lines. The second choice lets a slow writer follow the scan line by line and stay behind it.

Top module: `lcdt_raster`

## Requirements
- R1: While `rst_n` is low, `de_o`, `te_o`, `pclk_en_o`, `col_o` and `line_o` are 0, and both syncs sit at their inactive level. The scan restarts at line 0, column 0, which is the first sync cycle of the first sync line. On the first clock edge with `rst_n` high, both syncs become active at the outputs.
- R2: A line is `h_sync_len` + `h_back_len` + `h_act_len` + `h_front_len` clocks long, with the four parts in that order. `hsync_o` is active during the sync clocks only.
- R3: A frame is `v_sync_len` + `v_back_len` + `v_act_len` + `v_front_len` lines long, with the four parts in that order. `vsync_o` is active for every clock of the sync lines and switches together with the start of a line sync.
- R4: `de_o` is high only for clocks that lie in both the active columns and the active lines. A frame therefore has exactly `h_act_len` × `v_act_len` data-valid clocks.
- R5: A front porch of 0 is legal. The next sync then starts on the clock right after the last active pixel or the last active line.
- R6: `col_o` and `line_o` give the zero-based index of the pixel whose `de_o` appears one clock later, with the first pixel at column 0, line 0. They are 0 when the next clock carries no active pixel.
- R7: With `te_mode` = 0, `te_o` is high on every clock of non-active lines and low for the whole of each active line. With `te_mode` = 1, `te_o` is high whenever `de_o` would be low and low only on active pixels. `te_o` is aligned with `de_o`.
- R8: The eight length inputs and `te_mode` are captured during reset and at the start of each frame. A change in the middle of a frame first takes effect in the next frame.
- R9: `hs_pol` and `vs_pol` set the active level of `hsync_o` and `vsync_o` (1 = active high, 0 = active low) and act at once.
- R10: `pclk_en_o` is high on every clock after the first edge with `rst_n` high.

Sync lengths and active sizes must be at least 1. Porches may be 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_sync_len | input | 12 | Line sync length in clocks |
| h_back_len | input | 12 | Clocks between line sync and first active pixel |
| h_act_len | input | 12 | Active pixels per line |
| h_front_len | input | 12 | Clocks between last active pixel and next line sync |
| v_sync_len | input | 12 | Frame sync length in lines |
| v_back_len | input | 12 | Lines between frame sync and first active line |
| v_act_len | input | 12 | Active lines per frame |
| v_front_len | input | 12 | Lines between last active line and next frame sync |
| hs_pol | input | 1 | Active level of hsync_o |
| vs_pol | input | 1 | Active level of vsync_o |
| te_mode | input | 1 | 0: tearing flag marks vertical blanking only; 1: vertical and horizontal blanking |
| hsync_o | output | 1 | Line sync |
| vsync_o | output | 1 | Frame sync |
| pclk_en_o | output | 1 | Pixel-shift enable |
| de_o | output | 1 | Data valid |
| col_o | output | 12 | Column index to fetch, one clock ahead of de_o |
| line_o | output | 12 | Line index to fetch, one clock ahead of de_o |
| te_o | output | 1 | Tearing-effect flag to the host |

## Verification
Some properties are checked on every cycle:
- data-valid never overlaps an active line sync or a high tearing flag;
- an active frame sync always comes with a high tearing flag;
- the pixel-shift enable stays on after reset;
- inside a run of data-valid, the fetched column steps by one and the line holds, starting from column 0.

Other behaviour can only be shown by the bench scenarios, which compare each output against a behavioural model on every clock:
- exact line and frame lengths;
- the data-valid count per frame;
- zero-porch back-to-back sync;
- both tearing modes;
- polarity inversion;
- the rule that reprogramming in mid-frame only takes effect at the next frame boundary.

// File: rtl/lcdt_pkg.sv
// Shared types for the raster timing generator.
// Assumes every timing length fits the register width below.
package lcdt_pkg;
    // Width of every timing length and of the pixel indices.
    localparam int unsigned CFG_W = 12;
    // Position counters are wider so that the sum of four lengths cannot wrap.
    localparam int unsigned POS_W = CFG_W + 2;

    // One scan axis: sync, back porch, active span, front porch.
    typedef struct packed {
        logic [CFG_W-1:0] sync;
        logic [CFG_W-1:0] back;
        logic [CFG_W-1:0] act;
        logic [CFG_W-1:0] front;
    } axis_cfg_t;
endpackage

// File: rtl/lcdt_shadow.sv
// Holds the timing lengths and tearing mode used by the running frame.
// It captures the live inputs during reset and on the clock that closes a
// frame, so that a host write in mid-frame never changes the current frame.
module lcdt_shadow
    import lcdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  axis_cfg_t h_in,
    input  axis_cfg_t v_in,
    input  logic      te_mode_in,
    output axis_cfg_t h_cfg,
    output axis_cfg_t v_cfg,
    output logic      te_mode
);

    // Capture the configuration during reset or at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            h_cfg   <= h_in;
            v_cfg   <= v_in;
            te_mode <= te_mode_in;
        end
    end

endmodule

// File: rtl/lcdt_axis.sv
// Position counter for one scan axis (pixels in a line, or lines in a frame).
// It moves one step when 'step' is high and wraps after the front porch.
// It decodes the sync window, the active window and the zero-based index
// inside the active window.
// Assumes sync >= 1 and act >= 1; porches may be zero.
module lcdt_axis
    import lcdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  axis_cfg_t        cfg,
    output logic             last,
    output logic             in_sync,
    output logic             in_act,
    output logic [CFG_W-1:0] idx
);

    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] act_lo;
    logic [POS_W-1:0] act_hi;
    logic [POS_W-1:0] end_pos;

    // Window edges derived from the lengths.
    always_comb begin
        act_lo  = POS_W'(cfg.sync) + POS_W'(cfg.back);
        act_hi  = act_lo + POS_W'(cfg.act);
        end_pos = act_hi + POS_W'(cfg.front) - POS_W'(1);
    end

    // Decode the current position into windows and an active index.
    always_comb begin
        last    = (pos == end_pos);
        in_sync = (pos < POS_W'(cfg.sync));
        in_act  = (pos >= act_lo) && (pos < act_hi);
        idx     = in_act ? CFG_W'(pos - act_lo) : '0;
    end

    // Advance the position and wrap at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (step) begin
            pos <= last ? '0 : pos + POS_W'(1);
        end
    end

endmodule

// File: rtl/lcdt_raster.sv
// Raster timing generator for a RAM-less RGB panel.
// A horizontal counter steps on every clock. A vertical counter steps when a
// line wraps. The syncs, data-valid, tearing flag and pixel-shift enable are
// registered from the counter state, so the combinational col_o/line_o
// indices lead data-valid by one clock, which leaves room for one cycle of
// frame-buffer read latency.
// Assumes sync lengths and active sizes >= 1.
module lcdt_raster
    import lcdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] h_sync_len,
    input  logic [CFG_W-1:0] h_back_len,
    input  logic [CFG_W-1:0] h_act_len,
    input  logic [CFG_W-1:0] h_front_len,
    input  logic [CFG_W-1:0] v_sync_len,
    input  logic [CFG_W-1:0] v_back_len,
    input  logic [CFG_W-1:0] v_act_len,
    input  logic [CFG_W-1:0] v_front_len,
    input  logic             hs_pol,
    input  logic             vs_pol,
    input  logic             te_mode,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             pclk_en_o,
    output logic             de_o,
    output logic [CFG_W-1:0] col_o,
    output logic [CFG_W-1:0] line_o,
    output logic             te_o
);

    axis_cfg_t        h_live, v_live, h_cfg, v_cfg;
    logic             te_mode_s;
    logic             h_last, h_sync, h_act;
    logic             v_last, v_sync, v_act;
    logic [CFG_W-1:0] h_idx, v_idx;
    logic             frame_wrap, pix_act, te_raw;
    logic             hs_q, vs_q, de_q, te_q, pen_q;

    // Collect the live length inputs into axis records.
    always_comb begin
        h_live = '{sync: h_sync_len, back: h_back_len, act: h_act_len, front: h_front_len};
        v_live = '{sync: v_sync_len, back: v_back_len, act: v_act_len, front: v_front_len};
    end

    lcdt_shadow u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (frame_wrap),
        .h_in       (h_live),
        .v_in       (v_live),
        .te_mode_in (te_mode),
        .h_cfg      (h_cfg),
        .v_cfg      (v_cfg),
        .te_mode    (te_mode_s)
    );

    lcdt_axis u_h_axis (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (1'b1),
        .cfg     (h_cfg),
        .last    (h_last),
        .in_sync (h_sync),
        .in_act  (h_act),
        .idx     (h_idx)
    );

    lcdt_axis u_v_axis (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (h_last),
        .cfg     (v_cfg),
        .last    (v_last),
        .in_sync (v_sync),
        .in_act  (v_act),
        .idx     (v_idx)
    );

    // Frame boundary, active-pixel decode and tearing condition.
    always_comb begin
        frame_wrap = h_last && v_last;
        pix_act    = h_act && v_act;
        te_raw     = !v_act || (te_mode_s && !h_act);
    end

    // Fetch indices, one clock ahead of data-valid.
    always_comb begin
        col_o  = pix_act ? h_idx : '0;
        line_o = pix_act ? v_idx : '0;
    end

    // Register the panel strobes from the counter state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q  <= 1'b0;
            vs_q  <= 1'b0;
            de_q  <= 1'b0;
            te_q  <= 1'b0;
            pen_q <= 1'b0;
        end else begin
            hs_q  <= h_sync;
            vs_q  <= v_sync;
            de_q  <= pix_act;
            te_q  <= te_raw;
            pen_q <= 1'b1;
        end
    end

    // Apply the programmable sync polarity.
    always_comb begin
        hsync_o   = hs_pol ? hs_q : !hs_q;
        vsync_o   = vs_pol ? vs_q : !vs_q;
        de_o      = de_q;
        te_o      = te_q;
        pclk_en_o = pen_q;
    end

endmodule

// File: rtl/lcdt_raster_chk.sv
// Property checker for lcdt_raster, attached to every instance through bind.
// It only observes ports.
module lcdt_raster_chk
    import lcdt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             hs_pol,
    input logic             vs_pol,
    input logic             hsync_o,
    input logic             vsync_o,
    input logic             pclk_en_o,
    input logic             de_o,
    input logic [CFG_W-1:0] col_o,
    input logic [CFG_W-1:0] line_o,
    input logic             te_o
);

    // R10: shift enable stays on once out of reset.
    p_pclk_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pclk_en_o);

    // R2: data-valid never overlaps an active line sync.
    p_de_no_hsync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> (hsync_o != hs_pol));

    // R7: the tearing flag is low on every active pixel.
    p_de_te_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> !te_o);

    // R7: frame sync lines always lie in the non-display period.
    p_vsync_te_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_o == vs_pol) |-> te_o);

    // R6: a run of data-valid starts at column 0.
    p_first_col_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(de_o) |-> ($past(col_o) == '0));

    // R6: inside a run, the column steps by one.
    p_col_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (de_o && $past(de_o)) |-> ($past(col_o) == $past(col_o, 2) + CFG_W'(1)));

    // R6: inside a run, the line index holds.
    p_line_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (de_o && $past(de_o)) |-> ($past(line_o) == $past(line_o, 2)));

endmodule

bind lcdt_raster lcdt_raster_chk i_chk (.*);

// File: tb/test_lcdt_raster.sv
// Bench for lcdt_raster. A behavioural model with integer positions and a
// frame snapshot of the lengths runs on each rising edge. All outputs are
// compared with it on each falling edge.
module test_lcdt_raster;
    import lcdt_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst_n;
    logic [CFG_W-1:0] hsl, hbl, hal, hfl, vsl, vbl, val, vfl;
    logic             hsp, vsp, tem;
    logic             hsync_o, vsync_o, pclk_en_o, de_o, te_o;
    logic [CFG_W-1:0] col_o, line_o;

    lcdt_raster i_lcdt_raster (
        .clk(clk), .rst_n(rst_n),
        .h_sync_len(hsl), .h_back_len(hbl), .h_act_len(hal), .h_front_len(hfl),
        .v_sync_len(vsl), .v_back_len(vbl), .v_act_len(val), .v_front_len(vfl),
        .hs_pol(hsp), .vs_pol(vsp), .te_mode(tem),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .pclk_en_o(pclk_en_o),
        .de_o(de_o), .col_o(col_o), .line_o(line_o), .te_o(te_o)
    );

    int    checks = 0;
    int    errors = 0;
    string scen   = "startup";
    bit    cmp_en = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s] %s: actual %0d expected %0d", req, scen, what, act, exp);
        end
    endtask

    // Behavioural reference model.
    int m_hp, m_vp;
    int s_hs, s_hb, s_ha, s_hf, s_vs, s_vb, s_va, s_vf;
    bit s_tm;
    bit m_hs, m_vs, m_de, m_te, m_pe;

    function automatic bit h_active(input int p);
        return (p >= s_hs + s_hb) && (p < s_hs + s_hb + s_ha);
    endfunction

    function automatic bit v_active(input int p);
        return (p >= s_vs + s_vb) && (p < s_vs + s_vb + s_va);
    endfunction

    task automatic snap();
        s_hs = hsl; s_hb = hbl; s_ha = hal; s_hf = hfl;
        s_vs = vsl; s_vb = vbl; s_va = val; s_vf = vfl;
        s_tm = tem;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hp = 0; m_vp = 0; snap();
            m_hs = 0; m_vs = 0; m_de = 0; m_te = 0; m_pe = 0;
        end else begin
            m_hs = (m_hp < s_hs);
            m_vs = (m_vp < s_vs);
            m_de = h_active(m_hp) && v_active(m_vp);
            m_te = !v_active(m_vp) || (s_tm && !h_active(m_hp));
            m_pe = 1;
            if (m_hp == s_hs + s_hb + s_ha + s_hf - 1) begin
                m_hp = 0;
                if (m_vp == s_vs + s_vb + s_va + s_vf - 1) begin
                    m_vp = 0;
                    snap();
                end else begin
                    m_vp++;
                end
            end else begin
                m_hp++;
            end
        end
    end

    // Compare every output with the model on each falling edge.
    bit prev_de = 0;
    int de_to_sync = 0;
    always @(negedge clk) begin
        if (cmp_en) begin
            bit pa;
            int ecol, eline;
            pa    = h_active(m_hp) && v_active(m_vp);
            ecol  = pa ? m_hp - s_hs - s_hb : 0;
            eline = pa ? m_vp - s_vs - s_vb : 0;
            chk(hsync_o == (hsp ? m_hs : !m_hs), "R2/R9", "hsync_o", hsync_o, hsp ? m_hs : !m_hs);
            chk(vsync_o == (vsp ? m_vs : !m_vs), "R3/R9", "vsync_o", vsync_o, vsp ? m_vs : !m_vs);
            chk(de_o == m_de, "R4", "de_o", de_o, m_de);
            chk(te_o == m_te, "R7", "te_o", te_o, m_te);
            chk(pclk_en_o == m_pe, "R10", "pclk_en_o", pclk_en_o, m_pe);
            chk(int'(col_o) == ecol, "R6", "col_o", col_o, ecol);
            chk(int'(line_o) == eline, "R6", "line_o", line_o, eline);
            if (prev_de && !de_o && (hsync_o == hsp)) de_to_sync++;
            prev_de = de_o;
        end
    end

    task automatic check_reset_state();
        chk(de_o == 0, "R1", "de_o in reset", de_o, 0);
        chk(te_o == 0, "R1", "te_o in reset", te_o, 0);
        chk(pclk_en_o == 0, "R1", "pclk_en_o in reset", pclk_en_o, 0);
        chk(hsync_o == !hsp, "R1", "hsync_o in reset", hsync_o, !hsp);
        chk(vsync_o == !vsp, "R1", "vsync_o in reset", vsync_o, !vsp);
        chk(col_o == 0 && line_o == 0, "R1", "indices in reset", col_o, 0);
    endtask

    bit done = 0;

    initial begin
        rst_n = 0;
        hsl = 2; hbl = 3; hal = 8; hfl = 2;
        vsl = 2; vbl = 2; val = 5; vfl = 2;
        hsp = 1; vsp = 1; tem = 0;
        cmp_en = 1;
        repeat (3) @(negedge clk);
        scen = "reset state";
        check_reset_state();
        rst_n = 1;
        @(negedge clk);
        chk(vsync_o == vsp, "R1", "vsync_o after release", vsync_o, vsp);
        chk(hsync_o == hsp, "R1", "hsync_o after release", hsync_o, hsp);

        scen = "base timing";
        repeat (200) @(negedge clk);
        begin
            int n = 0;
            for (int i = 0; i < 165; i++) begin
                @(negedge clk);
                if (de_o) n++;
            end
            chk(n == 40, "R4", "data-valid clocks per frame", n, 40);
        end

        scen = "R7/R8 both-blank flag and mid-frame reprogram";
        tem = 1; hal = 6;
        repeat (340) @(negedge clk);

        scen = "R5/R9 zero front porch, low polarity";
        hfl = 0; vfl = 0; hsp = 0; vsp = 0;
        de_to_sync = 0;
        repeat (320) @(negedge clk);
        chk(de_to_sync > 0, "R5", "sync right after last pixel", de_to_sync, 1);

        scen = "R1 reset while running";
        rst_n = 0;
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1;
        @(negedge clk);
        chk(vsync_o == vsp, "R1", "vsync_o after second release", vsync_o, vsp);
        repeat (200) @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule